// File: doc/BRIEF.md
# Scatter-Gather Descriptor Queue

This block keeps an ordered queue of DMA descriptors that software builds through a small register interface, and presents them one at a time to a DMA engine over a valid/ready handshake. A descriptor is assembled from two staged words (length plus control flags, and the low address half). A third write supplies the high address half and commits the complete descriptor to the queue in the same write.

Two run modes exist. In single-shot mode every queued descriptor is handed out once, and the queue then drains to empty. In circular mode every descriptor handed out is written straight back to the tail in the same cycle, so one programmed list repeats without software help. A status word reports the position of the most recently issued descriptor within the current pass and the number of completed passes. Software uses it to follow the engine. A level readout, a sticky overflow flag and a write-to-clear strobe complete the register set.

Top module: `sg_desc_table`

Register word offsets on `csr_addr`: 0 = control (bit 0 run enable, bit 1 circular mode, read/write); 1 = staged length/flags word; 2 = staged low address; 3 = commit with high address; 4 = clear strobe (any written value); 5 = level (read only); 6 = pass status (read only); 7 = overflow flag in bit 0 (read only).

## Requirements
- R1: A write to offset 3 commits one descriptor. Its address is {written word, offset-2 word}. Its length is bits [23:0] of the offset-1 word, its IRQ-disable flag is bit 24 of that word and its last-disable flag is bit 25. These fields appear unchanged on the output when the descriptor is issued.
- R2: In single-shot mode (control bit 1 = 0), descriptors issue in commit order, each exactly once. `dsc_valid` is low when the queue is empty.
- R3: In circular mode (control bit 1 = 1), each issued descriptor re-enters the tail in the same cycle. The issue order repeats indefinitely and the level does not change.
- R4: While control bit 0 is 0, `dsc_valid` stays low and the queued descriptors are kept.
- R5: Offset 5 reads the number of descriptors held.
- R6: Any write to offset 4 empties the queue and clears the pass status and the overflow flag.
- R7: A commit that arrives while the queue holds DEPTH entries, and no descriptor issues in that cycle, is discarded. It sets the overflow flag (offset 7 bit 0), which stays set until a clear.
- R8: Offset 6 reads, in bits [15:0], the in-pass position of the last issued descriptor (counting from 0). Bits [31:16] hold the number of completed passes. A pass ends when the last entry of the list issues in circular mode, or when the queue drains in single-shot mode.
- R9: The pass count stops at 0xFFFF.
- R10: A control write that sets bit 0 while it was 0 clears the pass status.
- R11: In circular mode, a commit write holds `dsc_valid` low for that cycle, so no descriptor issues and the commit enters the queue.
- R12: While `dsc_valid` is high and `dsc_ready` is low, the offered descriptor is held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 4 | Register word offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational on csr_addr) |
| dsc_valid | output | 1 | Descriptor offered to the engine |
| dsc_ready | input | 1 | Engine accepts the offered descriptor |
| dsc_addr | output | 64 | Descriptor byte address |
| dsc_len | output | 24 | Descriptor byte length |
| dsc_irq_dis | output | 1 | Interrupt-disable flag of the descriptor |
| dsc_last_dis | output | 1 | Last-disable flag of the descriptor |

## Verification
A corrupted read or write pointer shows up on the very next handshake: the descriptor presented has the wrong address or length, or an issued entry comes back in circular mode out of order. A wrong occupancy count shows within a cycle as a level readout that drifts while circular issue runs, or as a commit accepted or refused at the wrong fill. A slip in the position or pass counters is visible at the status offset after the first wrapped pass. The saturation corner needs 65,535 passes before it appears.

// File: rtl/sgdt_pkg.sv
// Shared types and register offsets for the scatter-gather descriptor queue.
// Assumes a 64-bit byte address and a 24-bit byte length per descriptor.
package sgdt_pkg;

    localparam int ADDR_W = 64;
    localparam int LEN_W  = 24;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              irq_dis;
        logic              last_dis;
    } sgdt_desc_t;

    localparam int DESC_W = $bits(sgdt_desc_t);

    localparam logic [3:0] OFS_CTRL   = 4'd0;
    localparam logic [3:0] OFS_STLEN  = 4'd1;
    localparam logic [3:0] OFS_STLO   = 4'd2;
    localparam logic [3:0] OFS_COMMIT = 4'd3;
    localparam logic [3:0] OFS_CLEAR  = 4'd4;
    localparam logic [3:0] OFS_LEVEL  = 4'd5;
    localparam logic [3:0] OFS_PASS   = 4'd6;
    localparam logic [3:0] OFS_OVF    = 4'd7;

endpackage

// File: rtl/sgdt_fifo.sv
// Descriptor store: show-ahead circular queue of DEPTH entries.
// Assumes the caller never pushes while full unless it pops in the same
// cycle; a clear overrides push and pop. DEPTH need not be a power of two.
module sgdt_fifo #(
    parameter int DEPTH = 256,
    parameter int DW    = 90,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [LW-1:0] count,
    output logic          empty,
    output logic          full
);
    localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == LW'(DEPTH));

    // Store the pushed word at the tail slot.
    always_ff @(posedge clk) begin
        if (push && !clear) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LW'(DEPTH));

    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));

endmodule

// File: rtl/sgdt_loop_track.sv
// Pass tracker: records the in-pass position of each issued descriptor and
// counts completed passes, saturating at all ones.
// Assumes 'level' is the queue occupancy sampled in the issue cycle.
module sgdt_loop_track #(
    parameter int LW    = 9,
    parameter int IDX_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fire,
    input  logic             circ,
    input  logic [LW-1:0]    level,
    output logic [IDX_W-1:0] last_idx,
    output logic [CNT_W-1:0] pass_cnt
);
    localparam int CW = ((LW > IDX_W) ? LW : IDX_W) + 1;

    logic [IDX_W-1:0] pos;
    logic             wrap;

    // Decide whether the current issue closes a pass.
    always_comb begin
        if (circ) wrap = (CW'(pos) + CW'(1) >= CW'(level));
        else      wrap = (level == LW'(1));
    end

    // Update position, last index and pass count on each issue.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pos      <= '0;
            last_idx <= '0;
            pass_cnt <= '0;
        end else if (fire) begin
            last_idx <= pos;
            if (wrap) begin
                pos <= '0;
                if (pass_cnt != '1) pass_cnt <= pass_cnt + 1'b1;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    assert_count_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_cnt == '1 && !clr) |=> (pass_cnt == '1));

    assert_status_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (last_idx == '0 && pass_cnt == '0));

endmodule

// File: rtl/sgdt_csr.sv
// Register file: control bits, descriptor staging, commit/clear strobes,
// sticky overflow and the read multiplexer.
// Assumes one write per cycle; reads are combinational on the offset.
module sgdt_csr
    import sgdt_pkg::*;
#(
    parameter int LW = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic [LW-1:0] level,
    input  logic [15:0] last_idx,
    input  logic [15:0] pass_cnt,
    input  logic        commit_drop,
    output logic        run_en,
    output logic        circ,
    output logic        commit,
    output sgdt_desc_t  commit_desc,
    output logic        clear,
    output logic        en_rise
);
    logic [25:0] stage_len;
    logic [31:0] stage_lo;
    logic        ovf;
    logic        ctrl_wr;

    assign ctrl_wr = we && (addr == OFS_CTRL);
    assign commit  = we && (addr == OFS_COMMIT);
    assign clear   = we && (addr == OFS_CLEAR);
    assign en_rise = ctrl_wr && wdata[0] && !run_en;

    assign commit_desc.addr     = {wdata, stage_lo};
    assign commit_desc.len      = stage_len[23:0];
    assign commit_desc.irq_dis  = stage_len[24];
    assign commit_desc.last_dis = stage_len[25];

    // Hold control bits and staged descriptor words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en    <= 1'b0;
            circ      <= 1'b0;
            stage_len <= '0;
            stage_lo  <= '0;
        end else if (we) begin
            if (addr == OFS_CTRL) begin
                run_en <= wdata[0];
                circ   <= wdata[1];
            end
            if (addr == OFS_STLEN) stage_len <= wdata[25:0];
            if (addr == OFS_STLO)  stage_lo  <= wdata;
        end
    end

    // Sticky overflow flag, cleared only by the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) ovf <= 1'b0;
        else if (commit_drop) ovf <= 1'b1;
    end

    // Select the read word.
    always_comb begin
        case (addr)
            OFS_CTRL:  rdata = {30'd0, circ, run_en};
            OFS_STLEN: rdata = {6'd0, stage_len};
            OFS_STLO:  rdata = stage_lo;
            OFS_LEVEL: rdata = 32'(level);
            OFS_PASS:  rdata = {pass_cnt, last_idx};
            OFS_OVF:   rdata = {31'd0, ovf};
            default:   rdata = 32'd0;
        endcase
    end

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clear) |=> ovf);

endmodule

// File: rtl/sg_desc_table.sv
// Scatter-gather descriptor queue top. Joins the register file, the
// descriptor store and the pass tracker, and drives the valid/ready issue
// port. In circular mode an issued descriptor is pushed back in the same
// cycle; a commit in circular mode stalls issue for that cycle so the
// store needs a single write port.
module sg_desc_table
    import sgdt_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_we,
    input  logic [3:0]  csr_addr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    output logic        dsc_valid,
    input  logic        dsc_ready,
    output logic [63:0] dsc_addr,
    output logic [23:0] dsc_len,
    output logic        dsc_irq_dis,
    output logic        dsc_last_dis
);
    logic          run_en, circ, commit, clear, en_rise;
    logic          commit_drop, commit_ok, fire, push, empty, full;
    sgdt_desc_t    commit_desc, head, push_desc;
    logic [LW-1:0] level;
    logic [15:0]   last_idx, pass_cnt;

    sgdt_csr #(.LW(LW)) u_csr (
        .clk(clk), .rst_n(rst_n), .we(csr_we), .addr(csr_addr),
        .wdata(csr_wdata), .rdata(csr_rdata), .level(level),
        .last_idx(last_idx), .pass_cnt(pass_cnt), .commit_drop(commit_drop),
        .run_en(run_en), .circ(circ), .commit(commit),
        .commit_desc(commit_desc), .clear(clear), .en_rise(en_rise)
    );

    // Offer the head while running, unless a circular-mode commit claims the write port.
    always_comb begin
        dsc_valid = run_en && !empty && !(circ && commit);
        fire      = dsc_valid && dsc_ready;
        commit_ok = commit && (!full || fire);
        commit_drop = commit && !commit_ok;
        push      = commit_ok || (fire && circ);
        push_desc = (fire && circ) ? head : commit_desc;
    end

    sgdt_fifo #(.DEPTH(DEPTH), .DW(DESC_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(clear), .push(push),
        .push_data(push_desc), .pop(fire), .head(head), .count(level),
        .empty(empty), .full(full)
    );

    sgdt_loop_track #(.LW(LW)) u_track (
        .clk(clk), .rst_n(rst_n), .clr(clear || en_rise), .fire(fire),
        .circ(circ), .level(level), .last_idx(last_idx), .pass_cnt(pass_cnt)
    );

    assign dsc_addr     = head.addr;
    assign dsc_len      = head.len;
    assign dsc_irq_dis  = head.irq_dis;
    assign dsc_last_dis = head.last_dis;

    assert_circ_level_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (circ && fire && !clear) |=> (level == $past(level)));

    assert_hold_under_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_valid && !dsc_ready && !clear) |=> ($stable(dsc_addr) && $stable(dsc_len)));

    assert_no_issue_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !clear) |=> (level >= $past(level)));

endmodule

// File: tb/sg_desc_table_bench.sv
`timescale 1ns/1ps
module sg_desc_table_bench;
    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [3:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        dsc_valid;
    logic        dsc_ready = 1'b0;
    logic [63:0] dsc_addr;
    logic [23:0] dsc_len;
    logic        dsc_irq_dis, dsc_last_dis;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sg_desc_table #(.DEPTH(DEPTH)) u_sg_desc_table (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .dsc_valid(dsc_valid),
        .dsc_ready(dsc_ready), .dsc_addr(dsc_addr), .dsc_len(dsc_len),
        .dsc_irq_dis(dsc_irq_dis), .dsc_last_dis(dsc_last_dis)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(posedge clk); #1;
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic commit(input logic [23:0] len, input logic irq, input logic lst,
                          input logic [31:0] lo, input logic [31:0] hi);
        wr(4'd1, {6'd0, lst, irq, len});
        wr(4'd2, lo);
        wr(4'd3, hi);
    endtask

    // Check the offered descriptor, then accept it with one ready pulse.
    task automatic take(input string req, input logic [63:0] a, input logic [23:0] len,
                        input logic irq, input logic lst);
        @(negedge clk); #1;
        chk(req, {63'd0, dsc_valid}, 64'd1);
        chk(req, dsc_addr, a);
        chk(req, {40'd0, dsc_len}, {40'd0, len});
        chk(req, {62'd0, dsc_irq_dis, dsc_last_dis}, {62'd0, irq, lst});
        dsc_ready = 1'b1;
        @(posedge clk); #1;
        dsc_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk); #1;
        chk("R2 reset valid", {63'd0, dsc_valid}, 64'd0);
        rd(4'd5, d); chk("R5 reset level", 64'(d), 64'd0);
        rd(4'd6, d); chk("R8 reset status", 64'(d), 64'd0);
        rd(4'd0, d); chk("R4 reset control", 64'(d), 64'd0);
    endtask

    task automatic t_single_shot();
        logic [31:0] d;
        commit(24'h000100, 1'b1, 1'b0, 32'h1000_0000, 32'h0000_00A1);
        commit(24'h000200, 1'b0, 1'b1, 32'h2000_0000, 32'h0000_00A2);
        commit(24'hFFFFFF, 1'b1, 1'b1, 32'h3000_0004, 32'hFFFF_FFFF);
        @(negedge clk); #1;
        chk("R4 idle no valid", {63'd0, dsc_valid}, 64'd0);
        rd(4'd5, d); chk("R5 level three", 64'(d), 64'd3);
        wr(4'd0, 32'h1);
        take("R1 R2 first", 64'h0000_00A1_1000_0000, 24'h000100, 1'b1, 1'b0);
        rd(4'd6, d); chk("R8 index 0", 64'(d), 64'h0000_0000);
        take("R1 R2 second", 64'h0000_00A2_2000_0000, 24'h000200, 1'b0, 1'b1);
        rd(4'd6, d); chk("R8 index 1", 64'(d), 64'h0000_0001);
        take("R1 R2 third", 64'hFFFF_FFFF_3000_0004, 24'hFFFFFF, 1'b1, 1'b1);
        @(negedge clk); #1;
        chk("R2 empty no valid", {63'd0, dsc_valid}, 64'd0);
        rd(4'd5, d); chk("R5 drained", 64'(d), 64'd0);
        rd(4'd6, d); chk("R8 pass after drain", 64'(d), 64'h0001_0002);
    endtask

    task automatic t_circular();
        logic [31:0] d;
        logic [63:0] a0, a1;
        wr(4'd0, 32'h0);
        wr(4'd4, 32'h0);
        commit(24'h000010, 1'b0, 1'b0, 32'h0000_1000, 32'h0);
        commit(24'h000020, 1'b0, 1'b0, 32'h0000_2000, 32'h0);
        wr(4'd0, 32'h3);
        a0 = 64'h1000; a1 = 64'h2000;
        for (int i = 0; i < 5; i++) begin
            take("R3 circular order", (i % 2 == 0) ? a0 : a1,
                 (i % 2 == 0) ? 24'h10 : 24'h20, 1'b0, 1'b0);
            rd(4'd5, d); chk("R3 level steady", 64'(d), 64'd2);
        end
        rd(4'd6, d); chk("R8 two passes", 64'(d), 64'h0002_0000);
    endtask

    task automatic t_stall_hold();
        logic [63:0] a;
        @(negedge clk); #1;
        a = dsc_addr;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk("R12 held valid", {63'd0, dsc_valid}, 64'd1);
            chk("R12 held addr", dsc_addr, a);
        end
    endtask

    task automatic t_commit_stall();
        logic [31:0] d;
        @(negedge clk);
        csr_we = 1'b1; csr_addr = 4'd3; csr_wdata = 32'h0000_0077;
        dsc_ready = 1'b1;
        #1 chk("R11 valid low on commit", {63'd0, dsc_valid}, 64'd0);
        @(posedge clk); #1;
        csr_we = 1'b0; dsc_ready = 1'b0;
        rd(4'd5, d); chk("R11 commit accepted", 64'(d), 64'd3);
        @(negedge clk); #1;
        chk("R11 head not issued", dsc_addr, 64'h2000);
    endtask

    task automatic t_enable_rise();
        logic [31:0] d;
        wr(4'd0, 32'h2);
        @(negedge clk); #1;
        chk("R4 disabled no valid", {63'd0, dsc_valid}, 64'd0);
        rd(4'd5, d); chk("R4 queue kept", 64'(d), 64'd3);
        rd(4'd6, d); chk("R10 status kept while off", 64'(d), 64'h0002_0000);
        wr(4'd0, 32'h3);
        rd(4'd6, d); chk("R10 status cleared on enable", 64'(d), 64'd0);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        wr(4'd0, 32'h0);
        wr(4'd4, 32'h0);
        wr(4'd1, 32'h0000_0040);
        wr(4'd2, 32'hCAFE_0000);
        for (int i = 0; i < DEPTH; i++) wr(4'd3, 32'(i));
        rd(4'd5, d); chk("R7 full level", 64'(d), 64'(DEPTH));
        rd(4'd7, d); chk("R7 no flag yet", 64'(d), 64'd0);
        wr(4'd3, 32'h0000_0999);
        rd(4'd5, d); chk("R7 drop keeps level", 64'(d), 64'(DEPTH));
        rd(4'd7, d); chk("R7 flag set", 64'(d), 64'd1);
        wr(4'd0, 32'h0);
        rd(4'd7, d); chk("R7 flag sticky", 64'(d), 64'd1);
        wr(4'd0, 32'h1);
        take("R7 oldest kept", 64'h0000_0000_CAFE_0000, 24'h40, 1'b0, 1'b0);
        wr(4'd4, 32'h0);
        rd(4'd5, d); chk("R6 clear level", 64'(d), 64'd0);
        rd(4'd7, d); chk("R6 clear flag", 64'(d), 64'd0);
        rd(4'd6, d); chk("R6 clear status", 64'(d), 64'd0);
        @(negedge clk); #1;
        chk("R6 no valid after clear", {63'd0, dsc_valid}, 64'd0);
    endtask

    task automatic t_saturate();
        logic [31:0] d;
        wr(4'd0, 32'h0);
        commit(24'h8, 1'b0, 1'b0, 32'h5000, 32'h0);
        wr(4'd0, 32'h3);
        @(negedge clk);
        dsc_ready = 1'b1;
        repeat (65540) @(posedge clk);
        #1 dsc_ready = 1'b0;
        rd(4'd6, d); chk("R9 count saturated", 64'(d), 64'hFFFF_0000);
        rd(4'd5, d); chk("R3 single entry kept", 64'(d), 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_single_shot();
        t_circular();
        t_stall_hold();
        t_commit_stall();
        t_enable_rise();
        t_overflow();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule